// File: doc/BRIEF.md
# Cyclic-Netlist Combinationality Witness Checker

This block decides, for one fixed feedback netlist, whether a chosen set of assumed values on its broken feedback wires forms a self-consistent settled state that still carries an unknown value. The netlist has four two-input NAND gates arranged as two identical loops. In each loop the first gate takes input `a` and the loop's feedback wire. The second gate takes input `b` and the first gate's output, and it drives the feedback wire. Each feedback wire is cut and replaced by a pair of free assumption rails. The loop body is then evaluated in three-valued logic, with each value carried on two wires.

The rail-pair code is: `00` is logic 0, `11` is logic 1, and `01` or `10` is the unknown value. Each primary input drives both of its rails with the same bit. For each cut, the block reports whether the assumed pair agrees with the value recomputed at the cut point, and whether the assumed pair is unknown. It also reports a single witness flag. A bench or solver that sweeps every input and assumption value declares the netlist valid only if the witness flag never rises. For this netlist it does rise, and only when both `a` and `b` are 1.

All outputs are registered once, with a synchronous active-high reset.

Top module: `cyc_miter`

## Requirements
- R1: A synchronous reset clears `eq`, `undef` and `flag` to 0 on the next clock edge.
- R2: Each output reflects the inputs that were present at the previous rising clock edge (one cycle of latency).
- R3: `undef[0]` is the XOR of `d[1]` and `d[0]`, and `undef[1]` is the XOR of `e[1]` and `e[0]`.
- R4: `eq[i]` is 1 iff the assumed pair and the recomputed pair encode the same three-valued value. The codes are `00` for 0 and `11` for 1, and both `01` and `10` mean unknown, so the two unknown codes count as equal.
- R5: When `a` or `b` is 0, each recomputed cut value is the definite value NOT `b`, whatever the assumption rails hold.
- R6: When `a` and `b` are both 1, each loop passes its assumed value through unchanged in kind, so `eq` is `11` for every assumption.
- R7: `flag` is the AND of both `eq` bits, ANDed with the OR of both `undef` bits.
- R8: Over all 64 input and assumption assignments, `flag` is 1 for exactly 12 of them, all of which have `a` = `b` = 1. The netlist is therefore judged not combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 1 | Primary input feeding the first gate of each loop |
| b | input | 1 | Primary input feeding the second gate of each loop |
| d | input | 2 | Assumption rails for feedback cut 0 |
| e | input | 2 | Assumption rails for feedback cut 1 |
| eq | output | 2 | Per-cut agreement of assumed and recomputed values |
| undef | output | 2 | Per-cut unknown detector on the assumption rails |
| flag | output | 1 | Witness: consistent state containing an unknown |

## Verification
On every cycle, the assertions check the following:
- reset clearing;
- the per-cut XOR detectors;
- that controlling inputs force a definite cut value and keep the flag low;
- that with both inputs at 1 the loops agree with any assumption;
- that an unknown assumption under non-controlling inputs raises the flag.

Only the bench's exhaustive sweep can show the global verdict: exactly 12 of the 64 assignments are witnesses, and all of them lie at `a` = `b` = 1. The sweep also shows the exact agreement pattern for each definite assumption against the forced value, and the one-cycle alignment of results to stimulus.

// File: rtl/cyc_tern_pkg.sv
package cyc_tern_pkg;
  localparam int RAIL_W = 2;
  typedef logic [RAIL_W-1:0] rail_t;

  localparam rail_t TV_ZERO = 2'b00;
  localparam rail_t TV_ONE  = 2'b11;
  localparam rail_t TV_UNK  = 2'b01;

  function automatic logic tv_is_one(input rail_t v);
    return &v;
  endfunction

  function automatic logic tv_is_zero(input rail_t v);
    return ~|v;
  endfunction

  function automatic logic tv_is_unk(input rail_t v);
    return ^v;
  endfunction

  function automatic rail_t tv_from_bit(input logic x);
    return {RAIL_W{x}};
  endfunction
endpackage

// File: rtl/cyc_nand2.sv
module cyc_nand2
  import cyc_tern_pkg::*;
(
  input  rail_t x,
  input  rail_t y,
  output rail_t z
);
  logic out_one, out_zero;

  // A definite 0 on either side controls the gate; both at 1 give 0.
  assign out_one  = tv_is_zero(x) | tv_is_zero(y);
  assign out_zero = tv_is_one(x) & tv_is_one(y);

  always_comb begin
    if (out_one)       z = TV_ONE;
    else if (out_zero) z = TV_ZERO;
    else               z = TV_UNK;
  end
endmodule

// File: rtl/cyc_loop_cell.sv
module cyc_loop_cell
  import cyc_tern_pkg::*;
(
  input  rail_t in_a,
  input  rail_t in_b,
  input  rail_t cut_assumed,
  output rail_t cut_recomputed
);
  rail_t mid;

  cyc_nand2 u_front (.x(in_a), .y(cut_assumed), .z(mid));
  cyc_nand2 u_back  (.x(in_b), .y(mid),         .z(cut_recomputed));
endmodule

// File: rtl/cyc_cut_check.sv
module cyc_cut_check
  import cyc_tern_pkg::*;
(
  input  rail_t assumed,
  input  rail_t computed,
  output logic  match,
  output logic  unknown
);
  assign unknown = tv_is_unk(assumed);
  assign match   = (assumed == computed) | (tv_is_unk(assumed) & tv_is_unk(computed));
endmodule

// File: rtl/cyc_miter.sv
module cyc_miter
  import cyc_tern_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a,
  input  logic       b,
  input  logic [1:0] d,
  input  logic [1:0] e,
  output logic [1:0] eq,
  output logic [1:0] undef,
  output logic       flag
);
  localparam int NUM_CUT = 2;

  rail_t a_dr, b_dr;
  rail_t assumed  [NUM_CUT];
  rail_t recomp   [NUM_CUT];
  logic [NUM_CUT-1:0] eq_c, undef_c;
  logic witness_c;

  assign a_dr       = tv_from_bit(a);
  assign b_dr       = tv_from_bit(b);
  assign assumed[0] = d;
  assign assumed[1] = e;

  for (genvar g = 0; g < NUM_CUT; g++) begin : g_cut
    cyc_loop_cell u_cell (
      .in_a(a_dr), .in_b(b_dr),
      .cut_assumed(assumed[g]), .cut_recomputed(recomp[g])
    );
    cyc_cut_check u_chk (
      .assumed(assumed[g]), .computed(recomp[g]),
      .match(eq_c[g]), .unknown(undef_c[g])
    );
  end

  assign witness_c = (&eq_c) & (|undef_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      eq    <= '0;
      undef <= '0;
      flag  <= 1'b0;
    end else begin
      eq    <= eq_c;
      undef <= undef_c;
      flag  <= witness_c;
    end
  end

  // R1: reset clears every output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (eq == 2'b00 && undef == 2'b00 && !flag));

  // R3: per-cut unknown detector follows the assumption rails one cycle later
  assert_undef_xor_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (undef == {$past(e[1] ^ e[0]), $past(d[1] ^ d[0])}));

  // R4: an unknown assumption never agrees with a forced definite value
  assert_unk_vs_forced_R4: assert property (@(posedge clk) disable iff (rst)
    ((!a || !b) && (d[1] ^ d[0])) |=> !eq[0]);

  // R5: controlling inputs force cut 0 to NOT b
  assert_forced_value_R5: assert property (@(posedge clk) disable iff (rst)
    ((!a || !b) && d == {2{~b}}) |=> eq[0]);

  // R6: non-controlling inputs make both loops agree with any assumption
  assert_transparent_R6: assert property (@(posedge clk) disable iff (rst)
    (a && b) |=> (eq == 2'b11));

  // R7: an unknown assumption under non-controlling inputs is a witness
  assert_witness_R7: assert property (@(posedge clk) disable iff (rst)
    (a && b && (e[1] ^ e[0])) |=> flag);

  // R8: no witness while any input is controlling
  assert_no_witness_R8: assert property (@(posedge clk) disable iff (rst)
    (!a || !b) |=> !flag);
endmodule

// File: tb/sim_cyc_miter.sv
module sim_cyc_miter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b0, b = 1'b0;
  logic [1:0] d = 2'b00, e = 2'b00;
  logic [1:0] eq, undef;
  logic flag;

  always #2.5 clk = ~clk;   // 200 MHz

  cyc_miter u0 (.clk(clk), .rst(rst), .a(a), .b(b), .d(d), .e(e),
                .eq(eq), .undef(undef), .flag(flag));

  typedef struct packed {
    logic [1:0] eq;
    logic [1:0] undef;
    logic       flag;
    logic       is_rst;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0, n_flag = 0, n_flag_off = 0;
  bit sweeping = 0, cur_ab = 0, sweep_done = 0;
  logic cur_ab_q[$];

  // three-valued class: 0, 1, or 2 for unknown
  function automatic int kind(input logic [1:0] p);
    if (p == 2'b00) return 0;
    if (p == 2'b11) return 1;
    return 2;
  endfunction

  function automatic logic cut_eq(input logic ia, input logic ib, input logic [1:0] p);
    int rc;
    rc = (ia && ib) ? kind(p) : (ib ? 0 : 1);   // R5 forced NOT b, R6 pass-through
    return kind(p) == rc;                       // R4
  endfunction

  task automatic apply(input logic r, input logic ia, input logic ib,
                       input logic [1:0] id, input logic [1:0] ie);
    exp_t x;
    @(negedge clk);
    rst = r; a = ia; b = ib; d = id; e = ie;
    if (r) begin
      x = '{eq: 2'b00, undef: 2'b00, flag: 1'b0, is_rst: 1'b1};
    end else begin
      x.eq     = {cut_eq(ia, ib, ie), cut_eq(ia, ib, id)};
      x.undef  = {ie[1] ^ ie[0], id[1] ^ id[0]};          // R3
      x.flag   = (&x.eq) & (|x.undef);                     // R7
      x.is_rst = 1'b0;
    end
    exp_q.push_back(x);
    cur_ab_q.push_back(ia & ib);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: outputs registered at this edge belong to the oldest queued stimulus (R2)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t x;
        logic ab;
        x  = exp_q.pop_front();
        ab = cur_ab_q.pop_front();
        if (x.is_rst) begin
          check(eq == 2'b00 && undef == 2'b00 && !flag, "R1", "reset outputs",
                {eq, undef, flag}, 0);
        end else begin
          check(undef == x.undef, "R3", "undef", undef, x.undef);
          check(eq == x.eq, "R4/R5/R6 R2", "eq", eq, x.eq);
          check(flag == x.flag, "R7", "flag", flag, x.flag);
          if (sweeping && flag) begin
            n_flag++;
            if (!ab) n_flag_off++;
          end
        end
      end
    end
  end

  initial begin
    repeat (3) apply(1'b1, 1'b0, 1'b0, 2'b00, 2'b00);   // R1 reset state
    // R5: controlling inputs with definite and unknown assumptions
    apply(1'b0, 1'b0, 1'b1, 2'b00, 2'b10);
    apply(1'b0, 1'b1, 1'b0, 2'b11, 2'b01);
    // R6/R7: both inputs high, one unknown cut
    apply(1'b0, 1'b1, 1'b1, 2'b01, 2'b00);
    // R1: reset in mid-run clears a raised witness
    apply(1'b1, 1'b1, 1'b1, 2'b01, 2'b10);
    apply(1'b0, 1'b1, 1'b1, 2'b10, 2'b11);
    // R8: exhaustive sweep over a, b, d, e
    @(negedge clk);
    sweeping = 1;
    for (int k = 0; k < 64; k++)
      apply(1'b0, k[5], k[4], k[3:2], k[1:0]);
    apply(1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    sweeping = 0;
    check(n_flag == 12, "R8", "witness count", n_flag, 12);
    check(n_flag_off == 0, "R8", "witnesses with a controlling input", n_flag_off, 0);
    sweep_done = 1;
  end

  initial begin
    fork
      wait (sweep_done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule